// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block receives configuration words for a two-channel frequency synthesizer over a three-wire serial port made of a data line, a serial clock and a load-enable strobe. The three pins are asynchronous to the system clock. They pass through two-flop synchronisers, and their rising edges are detected in the system clock domain. Each detected serial-clock rise shifts one data bit into a 23-bit frame register. The most significant bit arrives first, so the last two bits shifted in are the control bits at the low end of the frame.

A rising edge of load enable commits the frame to one of four register groups. The two control bits choose the group: the reference divider of channel 1 or channel 2, or the main/swallow/option group of channel 1 or channel 2. Reference ratios below the legal minimum are rejected. The rejected word leaves its group untouched and sets a sticky error flag. All latched groups come out of registers, and nothing outside the serial port writes them, so loading works the same whatever state the synthesizer channels are in.

Top module: `cfg_serial_loader`

## Requirements
- R1: A synchronous active-high reset sets both reference ratios to 5, both main ratios to 5, and every swallow value, test select, prescaler select, polarity bit and output-select bit to 0. It also clears the error flag.
- R2: Each rising edge of `ser_clk` shifts `ser_data` into frame bit 0 and moves the older bits one place up. The first bit sent ends in bit 22 and only the last 23 bits count. Extra bits sent before a frame fall off the top and have no effect.
- R3: At load, frame bit 0 selects the channel (0 = channel 1, 1 = channel 2) and frame bit 1 selects the kind (0 = reference group, 1 = counter group). Exactly that one group is written, and every other group keeps its value.
- R4: In a reference frame, bits 17..4 hold the reference ratio with its LSB at bit 4. Bits 3..2 go to the test select (bit 3 to test_sel[1], bit 2 to test_sel[0]). Bits 22..18 are ignored.
- R5: In a counter frame, bit 2 is the output-select bit, bit 3 the prescaler-modulus select and bit 4 the phase-polarity bit. Bits 11..5 hold the swallow value and bits 22..12 the main ratio, each with its LSB at the lower index.
- R6: The group is written on the system clock edge that is the third edge after `ser_le` rises, counting the first edge that samples it high. Outputs are unchanged after the first and second edges.
- R7: A reference frame whose ratio is below 5 leaves both reference groups unchanged and sets `ratio_err`. The flag stays set until reset. A ratio of exactly 5 is accepted.
- R8: Serial clock edges without a rising edge of `ser_le` change no output. The shifted frame is still held and is committed by a later load-enable pulse alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial data line, asynchronous |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_le | input | 1 | Load-enable strobe, asynchronous |
| c1_ref_div | output | 14 | Channel 1 reference ratio |
| c1_test_sel | output | 2 | Channel 1 test select |
| c2_ref_div | output | 14 | Channel 2 reference ratio |
| c2_test_sel | output | 2 | Channel 2 test select |
| c1_main_div | output | 11 | Channel 1 main ratio |
| c1_swallow | output | 7 | Channel 1 swallow value |
| c1_presc_sel | output | 1 | Channel 1 prescaler-modulus select |
| c1_pd_pol | output | 1 | Channel 1 phase-polarity bit |
| c1_out_sel | output | 1 | Channel 1 output-select bit |
| c2_main_div | output | 11 | Channel 2 main ratio |
| c2_swallow | output | 7 | Channel 2 swallow value |
| c2_presc_sel | output | 1 | Channel 2 prescaler-modulus select |
| c2_pd_pol | output | 1 | Channel 2 phase-polarity bit |
| c2_out_sel | output | 1 | Channel 2 output-select bit |
| ratio_err | output | 1 | Sticky flag: a reference ratio below 5 was rejected |

## Verification
The bench builds the block with its default parameters: a 23-bit frame, field widths of 14, 7 and 11 bits, two synchroniser stages and a minimum reference ratio of 5. With these widths the all-ones field values 16383, 2047 and 127 can be driven, along with the reject boundary between ratios 4 and 5. Because the synchroniser depth is two, the three-edge load latency can be pinned to exact cycles. A behavioural model replays the pin history with a queue and is compared against every output on every clock. Directed checks cover leading junk bits, shifting without a load, and a reset in the middle of a run.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  // Destination code is {frame[1], frame[0]} = {kind, channel}
  typedef enum logic [1:0] {
    DST_REF_CH1 = 2'b00,
    DST_REF_CH2 = 2'b01,
    DST_CNT_CH1 = 2'b10,
    DST_CNT_CH2 = 2'b11
  } dest_e;

  localparam int CTRL_W = 2;
  localparam int NUM_CH = 2;
endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] dout_prev
);
  // STAGES synchroniser flops plus one history flop for edge detection
  logic [STAGES:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[STAGES-1:0], din};
  end

  assign dout      = stg[STAGES-1];
  assign dout_prev = stg[STAGES];
endmodule

// File: rtl/cfgld_shifter.sv
module cfgld_shifter #(
  parameter int FRAME_W = 23
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] frame
);
  always_ff @(posedge clk) begin
    if (rst)           frame <= '0;
    else if (shift_en) frame <= {frame[FRAME_W-2:0], bit_in};
  end

  // R2: the frame moves only on a detected serial clock rise
  p_hold_no_edge_r2: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(frame));
endmodule

// File: rtl/cfgld_bank.sv
module cfgld_bank
  import cfgld_pkg::*;
#(
  parameter int FRAME_W  = 23,
  parameter int REF_W    = 14,
  parameter int TST_W    = 2,
  parameter int SWL_W    = 7,
  parameter int MAIN_W   = 11,
  parameter int REF_MIN  = 5,
  parameter int DEF_REF  = 5,
  parameter int DEF_MAIN = 5
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           load,
  input  logic [FRAME_W-1:0]             frame,
  output logic [NUM_CH-1:0][REF_W-1:0]   ref_div,
  output logic [NUM_CH-1:0][TST_W-1:0]   test_sel,
  output logic [NUM_CH-1:0][MAIN_W-1:0]  main_div,
  output logic [NUM_CH-1:0][SWL_W-1:0]   swallow,
  output logic [NUM_CH-1:0]              presc_sel,
  output logic [NUM_CH-1:0]              pd_pol,
  output logic [NUM_CH-1:0]              out_sel,
  output logic                           ratio_err
);
  localparam int TST_LSB  = CTRL_W;
  localparam int REF_LSB  = TST_LSB + TST_W;
  localparam int OS_BIT   = CTRL_W;
  localparam int PS_BIT   = CTRL_W + 1;
  localparam int POL_BIT  = CTRL_W + 2;
  localparam int SWL_LSB  = CTRL_W + 3;
  localparam int MAIN_LSB = SWL_LSB + SWL_W;
  localparam logic [REF_W-1:0]  REF_MIN_V  = REF_W'(REF_MIN);
  localparam logic [REF_W-1:0]  DEF_REF_V  = REF_W'(DEF_REF);
  localparam logic [MAIN_W-1:0] DEF_MAIN_V = MAIN_W'(DEF_MAIN);

  dest_e             dest;
  logic              ch;
  logic              is_cnt;
  logic [REF_W-1:0]  ratio_f;
  logic              ratio_bad;
  logic              bad_ref;
  logic [NUM_CH-1:0] wr_ref;
  logic [NUM_CH-1:0] wr_cnt;

  assign dest      = dest_e'(frame[CTRL_W-1:0]);
  assign ch        = (dest == DST_REF_CH2) || (dest == DST_CNT_CH2);
  assign is_cnt    = (dest == DST_CNT_CH1) || (dest == DST_CNT_CH2);
  assign ratio_f   = frame[REF_LSB +: REF_W];
  assign ratio_bad = ratio_f < REF_MIN_V;
  assign bad_ref   = load && !is_cnt && ratio_bad;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
      assign wr_ref[c] = load && !is_cnt && !ratio_bad && (ch == 1'(c));
      assign wr_cnt[c] = load &&  is_cnt && (ch == 1'(c));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CH; c++) begin
        ref_div[c]   <= DEF_REF_V;
        test_sel[c]  <= '0;
        main_div[c]  <= DEF_MAIN_V;
        swallow[c]   <= '0;
        presc_sel[c] <= 1'b0;
        pd_pol[c]    <= 1'b0;
        out_sel[c]   <= 1'b0;
      end
      ratio_err <= 1'b0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_ref[c]) begin
          ref_div[c]  <= ratio_f;
          test_sel[c] <= frame[TST_LSB +: TST_W];
        end
        if (wr_cnt[c]) begin
          main_div[c]  <= frame[MAIN_LSB +: MAIN_W];
          swallow[c]   <= frame[SWL_LSB +: SWL_W];
          presc_sel[c] <= frame[PS_BIT];
          pd_pol[c]    <= frame[POL_BIT];
          out_sel[c]   <= frame[OS_BIT];
        end
      end
      if (bad_ref) ratio_err <= 1'b1;
    end
  end

  // R3: a load writes at most one destination group
  p_one_dest_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_ref, wr_cnt}));

  // R7: the error flag never clears outside reset
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ratio_err |=> ratio_err);

  // R7: a rejected ratio leaves the reference groups alone and flags
  p_reject_r7: assert property (@(posedge clk) disable iff (rst)
    bad_ref |=> (ratio_err && $stable(ref_div) && $stable(test_sel)));

  // R8: without a load pulse no latched group moves
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(ref_div) && $stable(main_div) && $stable(swallow)
               && $stable(test_sel) && $stable(presc_sel)
               && $stable(pd_pol) && $stable(out_sel)));
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
  parameter int FRAME_W     = 23,
  parameter int REF_W       = 14,
  parameter int TST_W       = 2,
  parameter int SWL_W       = 7,
  parameter int MAIN_W      = 11,
  parameter int SYNC_STAGES = 2,
  parameter int REF_MIN     = 5,
  parameter int DEF_REF     = 5,
  parameter int DEF_MAIN    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_data,
  input  logic              ser_clk,
  input  logic              ser_le,
  output logic [REF_W-1:0]  c1_ref_div,
  output logic [TST_W-1:0]  c1_test_sel,
  output logic [REF_W-1:0]  c2_ref_div,
  output logic [TST_W-1:0]  c2_test_sel,
  output logic [MAIN_W-1:0] c1_main_div,
  output logic [SWL_W-1:0]  c1_swallow,
  output logic              c1_presc_sel,
  output logic              c1_pd_pol,
  output logic              c1_out_sel,
  output logic [MAIN_W-1:0] c2_main_div,
  output logic [SWL_W-1:0]  c2_swallow,
  output logic              c2_presc_sel,
  output logic              c2_pd_pol,
  output logic              c2_out_sel,
  output logic              ratio_err
);
  import cfgld_pkg::*;

  localparam int PIN_W = 3;
  localparam int P_DAT = 0;
  localparam int P_CLK = 1;
  localparam int P_LE  = 2;

  logic [PIN_W-1:0] pin_s;
  logic [PIN_W-1:0] pin_p;
  logic             shift_en;
  logic             load;
  logic [FRAME_W-1:0] frame;

  logic [NUM_CH-1:0][REF_W-1:0]  ref_div;
  logic [NUM_CH-1:0][TST_W-1:0]  test_sel;
  logic [NUM_CH-1:0][MAIN_W-1:0] main_div;
  logic [NUM_CH-1:0][SWL_W-1:0]  swallow;
  logic [NUM_CH-1:0]             presc_sel;
  logic [NUM_CH-1:0]             pd_pol;
  logic [NUM_CH-1:0]             out_sel;

  cfgld_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .din       ({ser_le, ser_clk, ser_data}),
    .dout      (pin_s),
    .dout_prev (pin_p)
  );

  assign shift_en = pin_s[P_CLK] && !pin_p[P_CLK];
  assign load     = pin_s[P_LE]  && !pin_p[P_LE];

  cfgld_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .bit_in   (pin_s[P_DAT]),
    .frame    (frame)
  );

  cfgld_bank #(
    .FRAME_W (FRAME_W), .REF_W (REF_W), .TST_W (TST_W), .SWL_W (SWL_W),
    .MAIN_W (MAIN_W), .REF_MIN (REF_MIN), .DEF_REF (DEF_REF), .DEF_MAIN (DEF_MAIN)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .frame     (frame),
    .ref_div   (ref_div),
    .test_sel  (test_sel),
    .main_div  (main_div),
    .swallow   (swallow),
    .presc_sel (presc_sel),
    .pd_pol    (pd_pol),
    .out_sel   (out_sel),
    .ratio_err (ratio_err)
  );

  assign c1_ref_div   = ref_div[0];
  assign c1_test_sel  = test_sel[0];
  assign c2_ref_div   = ref_div[1];
  assign c2_test_sel  = test_sel[1];
  assign c1_main_div  = main_div[0];
  assign c1_swallow   = swallow[0];
  assign c1_presc_sel = presc_sel[0];
  assign c1_pd_pol    = pd_pol[0];
  assign c1_out_sel   = out_sel[0];
  assign c2_main_div  = main_div[1];
  assign c2_swallow   = swallow[1];
  assign c2_presc_sel = presc_sel[1];
  assign c2_pd_pol    = pd_pol[1];
  assign c2_out_sel   = out_sel[1];
endmodule

// File: tb/cfg_serial_loader_test.sv
module cfg_serial_loader_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sd = 1'b0, sc = 1'b0, le = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [13:0] c1_ref_div, c2_ref_div;
  logic [1:0]  c1_test_sel, c2_test_sel;
  logic [10:0] c1_main_div, c2_main_div;
  logic [6:0]  c1_swallow, c2_swallow;
  logic c1_presc_sel, c1_pd_pol, c1_out_sel;
  logic c2_presc_sel, c2_pd_pol, c2_out_sel;
  logic ratio_err;

  cfg_serial_loader uut (
    .clk(clk), .rst(rst), .ser_data(sd), .ser_clk(sc), .ser_le(le),
    .c1_ref_div(c1_ref_div), .c1_test_sel(c1_test_sel),
    .c2_ref_div(c2_ref_div), .c2_test_sel(c2_test_sel),
    .c1_main_div(c1_main_div), .c1_swallow(c1_swallow),
    .c1_presc_sel(c1_presc_sel), .c1_pd_pol(c1_pd_pol), .c1_out_sel(c1_out_sel),
    .c2_main_div(c2_main_div), .c2_swallow(c2_swallow),
    .c2_presc_sel(c2_presc_sel), .c2_pd_pol(c2_pd_pol), .c2_out_sel(c2_out_sel),
    .ratio_err(ratio_err)
  );

  int checks = 0;
  int fails  = 0;
  bit started = 1'b0;
  bit done    = 1'b0;

  // ---------------- behavioural reference model ----------------
  logic [2:0]  pq[$];          // pin history {le, sclk, data}, newest first
  logic [22:0] m_sh;
  int m_ref[2], m_tst[2], m_main[2], m_swl[2], m_ps[2], m_pol[2], m_os[2];
  int m_err;

  task automatic m_reset();
    m_sh = '0;
    for (int c = 0; c < 2; c++) begin
      m_ref[c] = 5; m_tst[c] = 0; m_main[c] = 5; m_swl[c] = 0;
      m_ps[c] = 0; m_pol[c] = 0; m_os[c] = 0;
    end
    m_err = 0;
  endtask

  task automatic m_load(logic [22:0] w);
    int c = int'(w[0]);
    if (!w[1]) begin
      if (w[17:4] < 14'd5) m_err = 1;
      else begin m_ref[c] = int'(w[17:4]); m_tst[c] = int'(w[3:2]); end
    end else begin
      m_main[c] = int'(w[22:12]); m_swl[c] = int'(w[11:5]);
      m_pol[c] = int'(w[4]); m_ps[c] = int'(w[3]); m_os[c] = int'(w[2]);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_reset();
      pq = '{3'b000, 3'b000, 3'b000};
    end else begin
      if (pq[1][2] && !pq[2][2]) m_load(m_sh);
      if (pq[1][1] && !pq[2][1]) m_sh = {m_sh[21:0], pq[1][0]};
      pq.push_front({le, sc, sd});
      void'(pq.pop_back());
    end
  end

  function automatic logic [74:0] obs_vec();
    return {c1_ref_div, c1_test_sel, c1_main_div, c1_swallow, c1_presc_sel, c1_pd_pol, c1_out_sel,
            c2_ref_div, c2_test_sel, c2_main_div, c2_swallow, c2_presc_sel, c2_pd_pol, c2_out_sel,
            ratio_err};
  endfunction

  function automatic logic [74:0] exp_vec();
    return {14'(m_ref[0]), 2'(m_tst[0]), 11'(m_main[0]), 7'(m_swl[0]),
            1'(m_ps[0]), 1'(m_pol[0]), 1'(m_os[0]),
            14'(m_ref[1]), 2'(m_tst[1]), 11'(m_main[1]), 7'(m_swl[1]),
            1'(m_ps[1]), 1'(m_pol[1]), 1'(m_os[1]), 1'(m_err)};
  endfunction

  // R6: every-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (obs_vec() !== exp_vec()) begin
        fails++;
        $display("FAIL R6 cycle model t=%0t actual=%h expected=%h", $time, obs_vec(), exp_vec());
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(logic [22:0] w, int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      sd = w[i]; sc = 1'b0; wait_n(3);
      sc = 1'b1; wait_n(3);
    end
    sc = 1'b0; wait_n(3);
  endtask

  task automatic pulse_le();
    le = 1'b1; wait_n(4);
    le = 1'b0; wait_n(4);
  endtask

  task automatic send(logic [22:0] w);
    shift_bits(w, 23);
    pulse_le();
  endtask

  function automatic logic [22:0] ref_word(logic ch, logic [1:0] t, logic [13:0] r);
    return {5'b10110, r, t, 1'b0, ch};
  endfunction

  function automatic logic [22:0] cnt_word(logic ch, logic [10:0] n, logic [6:0] a,
                                           logic pol, logic ps, logic os);
    return {n, a, pol, ps, os, 1'b1, ch};
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    wait_n(1);
    started = 1'b1;
    wait_n(2);
    rst = 1'b0;
    wait_n(2);

    // R1 reset state
    chk("R1 c1_ref_div", int'(c1_ref_div), 5);
    chk("R1 c2_ref_div", int'(c2_ref_div), 5);
    chk("R1 c1_main_div", int'(c1_main_div), 5);
    chk("R1 c2_swallow", int'(c2_swallow), 0);
    chk("R1 ratio_err", int'(ratio_err), 0);

    // R3 R4 reference frame to channel 1
    send(ref_word(1'b0, 2'b10, 14'd1234));
    chk("R4 c1_ref_div", int'(c1_ref_div), 1234);
    chk("R4 c1_test_sel", int'(c1_test_sel), 2);
    chk("R3 c2_ref_div untouched", int'(c2_ref_div), 5);

    // R4 maximum ratio to channel 2
    send(ref_word(1'b1, 2'b01, 14'd16383));
    chk("R4 c2_ref_div max", int'(c2_ref_div), 16383);
    chk("R4 c2_test_sel", int'(c2_test_sel), 1);
    chk("R3 c1_ref_div untouched", int'(c1_ref_div), 1234);

    // R5 counter frame channel 1, all-ones fields
    send(cnt_word(1'b0, 11'd2047, 7'd127, 1'b1, 1'b0, 1'b1));
    chk("R5 c1_main_div", int'(c1_main_div), 2047);
    chk("R5 c1_swallow", int'(c1_swallow), 127);
    chk("R5 c1_pd_pol", int'(c1_pd_pol), 1);
    chk("R5 c1_presc_sel", int'(c1_presc_sel), 0);
    chk("R5 c1_out_sel", int'(c1_out_sel), 1);
    chk("R3 c2_main_div untouched", int'(c2_main_div), 5);

    // R5 counter frame channel 2
    send(cnt_word(1'b1, 11'd100, 7'd0, 1'b0, 1'b1, 1'b0));
    chk("R5 c2_main_div", int'(c2_main_div), 100);
    chk("R5 c2_presc_sel", int'(c2_presc_sel), 1);
    chk("R5 c2_out_sel", int'(c2_out_sel), 0);
    chk("R3 c1_main_div untouched", int'(c1_main_div), 2047);
    chk("R3 c1_ref_div after counter load", int'(c1_ref_div), 1234);

    // R2 leading junk bits fall off
    shift_bits(23'h1F, 5);
    send(ref_word(1'b0, 2'b11, 14'd777));
    chk("R2 c1_ref_div after junk", int'(c1_ref_div), 777);
    chk("R2 c1_test_sel after junk", int'(c1_test_sel), 3);

    // R8 shifting without load changes nothing; a later LE alone commits
    shift_bits(ref_word(1'b1, 2'b00, 14'd42), 23);
    chk("R8 c2_ref_div held", int'(c2_ref_div), 16383);
    chk("R8 c1_ref_div held", int'(c1_ref_div), 777);
    pulse_le();
    chk("R8 c2_ref_div after lone LE", int'(c2_ref_div), 42);

    // R6 exact latency
    shift_bits(ref_word(1'b0, 2'b00, 14'd900), 23);
    le = 1'b1;
    wait_n(2);
    chk("R6 no update after 2 edges", int'(c1_ref_div), 777);
    wait_n(1);
    chk("R6 update on 3rd edge", int'(c1_ref_div), 900);
    le = 1'b0;
    wait_n(4);

    // R7 reject below minimum, accept boundary, flag sticks
    send(ref_word(1'b0, 2'b01, 14'd4));
    chk("R7 c1_ref_div kept on ratio 4", int'(c1_ref_div), 900);
    chk("R7 c1_test_sel kept on ratio 4", int'(c1_test_sel), 0);
    chk("R7 ratio_err set", int'(ratio_err), 1);
    send(ref_word(1'b0, 2'b01, 14'd5));
    chk("R7 ratio 5 accepted", int'(c1_ref_div), 5);
    chk("R7 ratio_err sticky", int'(ratio_err), 1);
    send(ref_word(1'b1, 2'b00, 14'd0));
    chk("R7 c2_ref_div kept on ratio 0", int'(c2_ref_div), 42);

    // R1 reset mid-run
    rst = 1'b1;
    wait_n(2);
    rst = 1'b0;
    wait_n(2);
    chk("R1 ratio_err cleared", int'(ratio_err), 0);
    chk("R1 c1_main_div default", int'(c1_main_div), 5);
    chk("R1 c2_ref_div default", int'(c2_ref_div), 5);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule